// File: doc/BRIEF.md
# CEC Transmit Message Buffer Controller

This block stages one outgoing message for a consumer-electronics-control bus. Software fills a small register file with the sender and receiver logical addresses, an opcode byte and up to `NUM_OPS` operand bytes. It then launches the message. The block hands the message, one byte at a time, to a downstream bit-level line engine over a valid/ready handshake. Bit timing, arbitration and the pin belong to that engine. After it takes the final byte of an attempt, the engine returns one acknowledge or negative-acknowledge result.

A negative acknowledge uses up one attempt, and the message is replayed from its first byte. This repeats until the programmed attempt budget is spent. A header-only "poll" message is launched by a single write to the receiver-address register. A self-clearing flush bit wipes the operand store and abandons any message in flight. Completion and exhaustion each set a sticky status flag that software clears by writing 1. Each flag has its own enable, and the enabled flags drive one interrupt line.

Top module: `cec_tx_stager`

## Requirements
- R1: After a synchronous active-low reset, every readable register returns 0, `tx_valid` is low and `irq` is low.
- R2: A full message is presented as a header byte, then the opcode (address 0x03), then operands from address 0x10 upward. The header carries the sender (address 0x01, bits 3:0) in bits 7:4 and the receiver (address 0x02, bits 3:0) in bits 3:0. `tx_last` marks the final byte. A byte that is offered stays offered, unchanged, until `tx_ready` is high.
- R3: Writing address 0x04 with bit 4 set launches a full message whose operand count is taken from bits 3:0. A count above `NUM_OPS` is clamped to `NUM_OPS`. The clamped count reads back at address 0x04.
- R4: Writing address 0x02 with bit 7 set launches a poll. Exactly one byte, the header, is sent with `tx_last` high.
- R5: The attempt budget is CTRL (address 0x00) bits 6:4 plus one, latched at launch. Every negative result restarts the message from the header byte until the budget is spent.
- R6: An acknowledge sets status-0 (address 0x05) bit 5. CTRL bits 6:4 then read back the number of attempts used minus one.
- R7: A negative result on the last permitted attempt sets status-1 (address 0x06) bit 1. CTRL bits 6:4 then read the attempts used minus one.
- R8: Writing 1 to a status bit clears it; a set in the same cycle wins. `irq` is the OR of status-0 bit 5 gated by enable-0 (address 0x07) bit 5 and status-1 bit 1 gated by enable-1 (address 0x08) bit 1.
- R9: CTRL bit 0 reads 1 from launch until completion, exhaustion or flush. A launch request made while busy or flushing is ignored: the message in flight keeps its latched header and count.
- R10: Writing 1 to CTRL bit 7 starts a flush. That bit reads 1 for exactly `NUM_OPS` cycles and then clears itself. The flush zeroes every operand register, abandons any message in flight without setting a status flag, and blocks operand writes and launches while it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| tx_valid | output | 1 | A message byte is offered to the line engine |
| tx_data | output | 8 | Offered message byte |
| tx_last | output | 1 | Offered byte is the final byte of the attempt |
| tx_ready | input | 1 | Line engine takes the offered byte |
| res_valid | input | 1 | Line engine reports the result of an attempt |
| res_ack | input | 1 | Result is an acknowledge (1) or negative acknowledge (0) |
| irq | output | 1 | Enabled status flags, ORed |

## Verification
The hardest situations to reach from the ports are the collisions. One is a launch request that arrives while a message is stalled mid-byte. The other is a flush that cuts into an attempt in flight. The bench reaches both by holding `tx_ready` low from its line-engine model, which parks the sequencer on a known byte. It then writes a second launch, a poll, or the flush bit, and compares every clock against the reference model. A scripted engine returns a chosen number of negative results before the acknowledge, or negative results forever, so that every attempt budget ends in success on the final try or in exhaustion.

// File: rtl/cec_tx_pkg.sv
// Package: register addresses, field positions and the sequencer state type
// shared by the transmit stager and its sub-blocks.
package cec_tx_pkg;
    localparam int A_CTRL  = 0;    // flush(7) | retry field(6:4) | busy(0)
    localparam int A_INIT  = 1;    // sender address, bits 3:0
    localparam int A_DEST  = 2;    // receiver address 3:0, bit 7 launches a poll
    localparam int A_OPC   = 3;    // opcode byte
    localparam int A_XMIT  = 4;    // operand count 3:0, bit 4 launches
    localparam int A_STAT0 = 5;    // bit 5 done
    localparam int A_STAT1 = 6;    // bit 1 retries exhausted
    localparam int A_EN0   = 7;
    localparam int A_EN1   = 8;

    localparam int DONE_BIT  = 5;
    localparam int FAIL_BIT  = 1;
    localparam int FLUSH_BIT = 7;
    localparam int GO_BIT    = 4;
    localparam int POLL_BIT  = 7;
    localparam int LIM_W     = 3;  // retry field width
    localparam int CNT_W     = 4;  // operand count field width

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } tx_state_e;
endpackage

// File: rtl/cec_tx_regfile.sv
// Register file: holds the address, opcode, count and retry fields and the
// operand store. It runs the self-clearing flush that zeroes one operand slot
// per cycle and decodes the two launch writes.
// Assumes: the opcode and operands are not rewritten while a message is busy.
module cec_tx_regfile
    import cec_tx_pkg::*;
#(
    parameter int NUM_OPS = 14,
    parameter int ADDR_W  = 5,
    parameter int OP_BASE = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [7:0]                wr_data,
    input  logic                      busy,
    input  logic                      fin_valid,
    input  logic [LIM_W-1:0]          fin_attempts,
    output logic [3:0]                init_q,
    output logic [3:0]                dest_q,
    output logic [7:0]                opc_q,
    output logic [CNT_W-1:0]          cnt_q,
    output logic [LIM_W-1:0]          field_q,
    output logic [NUM_OPS-1:0][7:0]   ops_q,
    output logic                      flush_active,
    output logic                      start_full,
    output logic                      start_poll,
    output logic [7:0]                start_hdr,
    output logic [CNT_W-1:0]          start_cnt
);
    localparam int OP_W = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1;

    logic            wr_ctrl, wr_init, wr_dest, wr_opc, wr_xmit, wr_is_op;
    logic [OP_W-1:0] wr_op_idx;
    logic [OP_W-1:0] fl_cnt;
    logic [CNT_W-1:0] cnt_in;

    // Decode the write address into per-register strobes.
    always_comb begin
        wr_ctrl   = wr_en && (wr_addr == ADDR_W'(A_CTRL));
        wr_init   = wr_en && (wr_addr == ADDR_W'(A_INIT));
        wr_dest   = wr_en && (wr_addr == ADDR_W'(A_DEST));
        wr_opc    = wr_en && (wr_addr == ADDR_W'(A_OPC));
        wr_xmit   = wr_en && (wr_addr == ADDR_W'(A_XMIT));
        wr_is_op  = wr_en && (int'(wr_addr) >= OP_BASE) && (int'(wr_addr) < OP_BASE + NUM_OPS);
        wr_op_idx = OP_W'(int'(wr_addr) - OP_BASE);
    end

    // Clamp the requested operand count to the store depth.
    always_comb begin
        if (wr_data[CNT_W-1:0] > CNT_W'(NUM_OPS)) cnt_in = CNT_W'(NUM_OPS);
        else                                      cnt_in = wr_data[CNT_W-1:0];
    end

    // Launch requests, refused while busy or flushing.
    always_comb begin
        start_full = wr_xmit && wr_data[GO_BIT]   && !busy && !flush_active;
        start_poll = wr_dest && wr_data[POLL_BIT] && !busy && !flush_active;
        start_hdr  = {init_q, start_poll ? wr_data[3:0] : dest_q};
        start_cnt  = cnt_in;
    end

    // Plain configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= '0;
            dest_q <= '0;
            opc_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_init) init_q <= wr_data[3:0];
            if (wr_dest) dest_q <= wr_data[3:0];
            if (wr_opc)  opc_q  <= wr_data;
            if (wr_xmit) cnt_q  <= cnt_in;
        end
    end

    // Retry field: end-of-message report takes priority over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)         field_q <= '0;
        else if (fin_valid) field_q <= fin_attempts;
        else if (wr_ctrl)   field_q <= wr_data[6:4];
    end

    // Flush walker: one operand slot per cycle, then self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_active <= 1'b0;
            fl_cnt       <= '0;
        end else if (flush_active) begin
            if (fl_cnt == OP_W'(NUM_OPS - 1)) begin
                flush_active <= 1'b0;
                fl_cnt       <= '0;
            end else begin
                fl_cnt <= fl_cnt + 1'b1;
            end
        end else if (wr_ctrl && wr_data[FLUSH_BIT]) begin
            flush_active <= 1'b1;
        end
    end

    for (genvar s = 0; s < NUM_OPS; s++) begin : g_slot
        logic [7:0] val_q;
        // One operand slot: cleared by the walker, else written by software.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   val_q <= '0;
            else if (flush_active && fl_cnt == OP_W'(s))  val_q <= '0;
            else if (!flush_active && wr_is_op && wr_op_idx == OP_W'(s)) val_q <= wr_data;
        end
        assign ops_q[s] = val_q;
    end

    // R10
    flush_clears_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_active) |-> (ops_q == '0));
    // R6
    field_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_valid |=> (field_q == $past(fin_attempts)));
endmodule

// File: rtl/cec_tx_framer.sv
// Framer: walks header, opcode and operands out over valid/ready, waits for
// the per-attempt result, replays on a negative result until the latched
// budget is spent, and abandons the message on abort.
// Assumes: the line engine returns exactly one result after the last byte.
module cec_tx_framer
    import cec_tx_pkg::*;
#(
    parameter int NUM_OPS = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_full,
    input  logic                      start_poll,
    input  logic [7:0]                start_hdr,
    input  logic [CNT_W-1:0]          start_cnt,
    input  logic [LIM_W-1:0]          start_lim,
    input  logic [7:0]                opcode,
    input  logic [NUM_OPS-1:0][7:0]   ops,
    input  logic                      abort,
    output logic                      tx_valid,
    output logic [7:0]                tx_data,
    output logic                      tx_last,
    input  logic                      tx_ready,
    input  logic                      res_valid,
    input  logic                      res_ack,
    output logic                      busy,
    output logic                      fin_ok,
    output logic                      fin_fail,
    output logic [LIM_W-1:0]          fin_attempts
);
    localparam int IDX_W = $clog2(NUM_OPS + 2);
    localparam int OP_W  = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1;

    tx_state_e        state;
    logic [IDX_W-1:0] idx, last_idx;
    logic [7:0]       hdr_l;
    logic [LIM_W-1:0] lim_l, att;
    logic [OP_W-1:0]  op_sel;
    logic             res_take;

    // Sequencer: launch, byte walk, result wait, replay or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            last_idx <= '0;
            hdr_l    <= '0;
            lim_l    <= '0;
            att      <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start_full || start_poll) begin
                    state    <= ST_SEND;
                    idx      <= '0;
                    hdr_l    <= start_hdr;
                    last_idx <= start_poll ? '0 : IDX_W'(start_cnt) + IDX_W'(1);
                    lim_l    <= start_lim;
                    att      <= '0;
                end
                ST_SEND: if (abort) begin
                    state <= ST_IDLE;
                end else if (tx_ready) begin
                    if (idx == last_idx) state <= ST_WAIT;
                    else                 idx   <= idx + 1'b1;
                end
                ST_WAIT: if (abort) begin
                    state <= ST_IDLE;
                end else if (res_valid) begin
                    if (res_ack || att == lim_l) begin
                        state <= ST_IDLE;
                    end else begin
                        att   <= att + 1'b1;
                        idx   <= '0;
                        state <= ST_SEND;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Byte selection for the current position in the message.
    always_comb begin
        op_sel = OP_W'(idx - IDX_W'(2));
        if (idx == '0)            tx_data = hdr_l;
        else if (idx == IDX_W'(1)) tx_data = opcode;
        else                      tx_data = ops[op_sel];
        tx_valid = (state == ST_SEND);
        tx_last  = (idx == last_idx);
        busy     = (state != ST_IDLE);
    end

    // End-of-message reports to the status and retry-field logic.
    always_comb begin
        res_take     = (state == ST_WAIT) && !abort && res_valid;
        fin_ok       = res_take && res_ack;
        fin_fail     = res_take && !res_ack && (att == lim_l);
        fin_attempts = att;
    end

    // R2
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !abort) |=> (tx_valid && $stable(tx_data)));
    // R2
    last_ends_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);
    // R5
    attempt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (att <= lim_l));
    // R4
    poll_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && last_idx == '0) |-> tx_last);
endmodule

// File: rtl/cec_tx_intr.sv
// Status and interrupt: sticky done and exhausted flags with write-1-to-clear,
// their enable registers, and the combined interrupt line.
// Assumes: a set and a clear in the same cycle resolve to set.
module cec_tx_intr
    import cec_tx_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              fin_ok,
    input  logic              fin_fail,
    output logic              done_q,
    output logic              fail_q,
    output logic [7:0]        en0_q,
    output logic [7:0]        en1_q,
    output logic              irq
);
    logic clr_done, clr_fail;

    // Write-1-to-clear decode.
    always_comb begin
        clr_done = wr_en && (wr_addr == ADDR_W'(A_STAT0)) && wr_data[DONE_BIT];
        clr_fail = wr_en && (wr_addr == ADDR_W'(A_STAT1)) && wr_data[FAIL_BIT];
    end

    // Sticky flags, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= fin_ok   || (done_q && !clr_done);
            fail_q <= fin_fail || (fail_q && !clr_fail);
        end
    end

    // Enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en0_q <= '0;
            en1_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_EN0)) en0_q <= wr_data;
            if (wr_addr == ADDR_W'(A_EN1)) en1_q <= wr_data;
        end
    end

    // Interrupt line from enabled flags.
    assign irq = (done_q && en0_q[DONE_BIT]) || (fail_q && en1_q[FAIL_BIT]);

    // R6
    done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_ok |=> done_q);
    // R7
    fail_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_fail |=> fail_q);
endmodule

// File: rtl/cec_tx_stager.sv
// Top: CEC transmit message buffer controller. Joins the register file, the
// framer and the status block, and provides the combinational read port.
// Assumes: one register write per cycle; reads have no side effects.
module cec_tx_stager
    import cec_tx_pkg::*;
#(
    parameter int NUM_OPS = 14,
    parameter int ADDR_W  = 5,
    parameter int OP_BASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              res_valid,
    input  logic              res_ack,
    output logic              irq
);
    localparam int OP_W = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1;

    logic [3:0]              init_q, dest_q;
    logic [7:0]              opc_q, en0_q, en1_q, start_hdr;
    logic [CNT_W-1:0]        cnt_q, start_cnt;
    logic [LIM_W-1:0]        field_q, fin_attempts;
    logic [NUM_OPS-1:0][7:0] ops_q;
    logic                    flush_active, start_full, start_poll;
    logic                    busy, fin_ok, fin_fail, done_q, fail_q;
    logic [OP_W-1:0]         rd_op_idx;

    cec_tx_regfile #(.NUM_OPS(NUM_OPS), .ADDR_W(ADDR_W), .OP_BASE(OP_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .fin_valid(fin_ok || fin_fail), .fin_attempts(fin_attempts),
        .init_q(init_q), .dest_q(dest_q), .opc_q(opc_q), .cnt_q(cnt_q),
        .field_q(field_q), .ops_q(ops_q), .flush_active(flush_active),
        .start_full(start_full), .start_poll(start_poll),
        .start_hdr(start_hdr), .start_cnt(start_cnt)
    );

    cec_tx_framer #(.NUM_OPS(NUM_OPS)) u_framer (
        .clk(clk), .rst_n(rst_n), .start_full(start_full), .start_poll(start_poll),
        .start_hdr(start_hdr), .start_cnt(start_cnt), .start_lim(field_q),
        .opcode(opc_q), .ops(ops_q), .abort(flush_active),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .res_valid(res_valid), .res_ack(res_ack), .busy(busy),
        .fin_ok(fin_ok), .fin_fail(fin_fail), .fin_attempts(fin_attempts)
    );

    cec_tx_intr #(.ADDR_W(ADDR_W)) u_intr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fin_ok(fin_ok), .fin_fail(fin_fail), .done_q(done_q), .fail_q(fail_q),
        .en0_q(en0_q), .en1_q(en1_q), .irq(irq)
    );

    // Read port: register select by address.
    always_comb begin
        rd_op_idx = OP_W'(int'(rd_addr) - OP_BASE);
        rd_data   = '0;
        if ((int'(rd_addr) >= OP_BASE) && (int'(rd_addr) < OP_BASE + NUM_OPS)) begin
            rd_data = ops_q[rd_op_idx];
        end else begin
            case (int'(rd_addr))
                A_CTRL:  rd_data = {flush_active, field_q, 3'b000, busy};
                A_INIT:  rd_data = {4'h0, init_q};
                A_DEST:  rd_data = {4'h0, dest_q};
                A_OPC:   rd_data = opc_q;
                A_XMIT:  rd_data = 8'(cnt_q);
                A_STAT0: rd_data = 8'(done_q) << DONE_BIT;
                A_STAT1: rd_data = 8'(fail_q) << FAIL_BIT;
                A_EN0:   rd_data = en0_q;
                A_EN1:   rd_data = en1_q;
                default: rd_data = '0;
            endcase
        end
    end

    // R9
    busy_flush_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_active) |=> !busy);
endmodule

// File: tb/cec_tx_stager_tb.sv
module cec_tx_stager_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic [4:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic [4:0] rd_addr = 0;
    logic [7:0] rd_data;
    logic       tx_valid, tx_last, irq;
    logic [7:0] tx_data;
    logic       tx_ready = 1;
    logic       res_valid = 0;
    logic       res_ack = 0;

    always #5 clk = ~clk;

    cec_tx_stager u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .res_valid(res_valid), .res_ack(res_ack),
        .irq(irq)
    );

    int errors = 0;
    int checks = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_q[$];
    logic [7:0] m_ops[14];
    int  m_idx, m_att, m_lim, m_field, m_fc, m_cnt;
    bit  m_busy, m_wait, m_fl, m_done, m_fail;
    logic [3:0] m_init, m_dest;
    logic [7:0] m_opc, m_en0, m_en1;

    function automatic int clampc(input logic [7:0] d);
        return (int'(d[3:0]) > 14) ? 14 : int'(d[3:0]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            foreach (m_ops[i]) m_ops[i] = 0;
            m_idx = 0; m_att = 0; m_lim = 0; m_field = 0; m_fc = 0; m_cnt = 0;
            m_busy = 0; m_wait = 0; m_fl = 0; m_done = 0; m_fail = 0;
            m_init = 0; m_dest = 0; m_opc = 0; m_en0 = 0; m_en1 = 0;
        end else begin
            bit old_busy, old_fl, fin, st_full, st_poll, set_d, set_f;
            old_busy = m_busy; old_fl = m_fl; fin = 0; set_d = 0; set_f = 0;
            st_full = wr_en && wr_addr == 4 && wr_data[4] && !old_busy && !old_fl;
            st_poll = wr_en && wr_addr == 2 && wr_data[7] && !old_busy && !old_fl;
            if (old_busy) begin
                if (old_fl) m_busy = 0;
                else if (!m_wait) begin
                    if (tx_ready) begin
                        if (m_idx == m_q.size() - 1) m_wait = 1;
                        else m_idx++;
                    end
                end else if (res_valid) begin
                    if (res_ack) begin set_d = 1; fin = 1; m_field = m_att; m_busy = 0; end
                    else if (m_att == m_lim) begin set_f = 1; fin = 1; m_field = m_att; m_busy = 0; end
                    else begin m_att++; m_idx = 0; m_wait = 0; end
                end
            end
            if (st_full || st_poll) begin
                m_q.delete();
                m_q.push_back({m_init, st_poll ? wr_data[3:0] : m_dest});
                if (st_full) begin
                    m_q.push_back(m_opc);
                    for (int i = 0; i < clampc(wr_data); i++) m_q.push_back(m_ops[i]);
                end
                m_busy = 1; m_idx = 0; m_wait = 0; m_att = 0; m_lim = m_field;
            end
            if (old_fl) begin
                m_ops[m_fc] = 0;
                if (m_fc == 13) begin m_fl = 0; m_fc = 0; end
                else m_fc++;
            end
            if (wr_en) begin
                case (int'(wr_addr))
                    0: begin
                        if (!fin) m_field = int'(wr_data[6:4]);
                        if (wr_data[7] && !old_fl) begin m_fl = 1; m_fc = 0; end
                    end
                    1: m_init = wr_data[3:0];
                    2: m_dest = wr_data[3:0];
                    3: m_opc = wr_data;
                    4: m_cnt = clampc(wr_data);
                    5: if (wr_data[5]) m_done = 0;
                    6: if (wr_data[1]) m_fail = 0;
                    7: m_en0 = wr_data;
                    8: m_en1 = wr_data;
                    default: if (wr_addr >= 16 && wr_addr < 30 && !old_fl) m_ops[wr_addr - 16] = wr_data;
                endcase
            end
            if (set_d) m_done = 1;
            if (set_f) m_fail = 1;
        end
    end

    function automatic int exp_rd(input int a);
        case (a)
            0: return (int'(m_fl) << 7) | (m_field << 4) | int'(m_busy);
            1: return int'(m_init);
            2: return int'(m_dest);
            3: return int'(m_opc);
            4: return m_cnt;
            5: return int'(m_done) << 5;
            6: return int'(m_fail) << 1;
            7: return int'(m_en0);
            8: return int'(m_en1);
            default: return (a >= 16 && a < 30) ? int'(m_ops[a - 16]) : 0;
        endcase
    endfunction

    function automatic string rq(input int a);
        case (a)
            0: return "R9";
            1, 2, 3: return "R2";
            4: return "R3";
            5: return "R6";
            6: return "R7";
            7, 8: return "R8";
            default: return "R10";
        endcase
    endfunction

    // ---------------- per-clock comparison ----------------
    bit hold = 0;
    int rot = 0;
    always begin
        @(posedge clk);
        #3;
        if (rst_n) begin
            bit ev;
            ev = m_busy && !m_wait;
            chk("R2", int'(tx_valid), int'(ev));
            if (ev) begin
                chk("R2", int'(tx_data), int'(m_q[m_idx]));
                chk("R4", int'(tx_last), int'(m_idx == m_q.size() - 1));
            end
            chk("R8", int'(irq), int'((m_done && m_en0[5]) || (m_fail && m_en1[1])));
            chk(rq(int'(rd_addr)), int'(rd_data), exp_rd(int'(rd_addr)));
            if (!hold) begin
                rot = (rot + 1) % 23;
                rd_addr = (rot < 9) ? 5'(rot) : 5'(16 + rot - 9);
            end
        end
    end

    // ---------------- line engine model ----------------
    int acc_last = 0, served = 0, nack_left = 0, rmode = 0;
    bit nack_all = 0;
    logic [7:0] lfsr = 8'h5a;
    logic [7:0] cap[$];

    always @(posedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            cap.push_back(tx_data);
            if (tx_last) acc_last++;
        end
    end

    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? 1'b0 : lfsr[0];
        if (res_valid) res_valid = 0;
        else if (acc_last != served) begin
            served++;
            res_valid = 1;
            if (nack_all) res_ack = 0;
            else if (nack_left > 0) begin res_ack = 0; nack_left--; end
            else res_ack = 1;
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL R9 watchdog: actual=hung expected=idle");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1; wr_addr = 5'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        hold = 1; rd_addr = 5'(a);
        #1 d = int'(rd_data);
        hold = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin @(negedge clk); n++; end
        while ((m_busy || m_fl || acc_last != served || res_valid) && n < 3000);
        repeat (2) @(negedge clk);
    endtask

    int v;
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", int'(tx_valid), 0);
        chk("R1", int'(irq), 0);
        rd(0, v); chk("R1", v, 0);
        rd(5, v); chk("R1", v, 0);

        // R2 basic full message
        wr(7, 8'h20); wr(8, 8'h02);
        wr(1, 4); wr(2, 0); wr(3, 8'h36);
        wr(16, 8'hA1); wr(17, 8'hB2); wr(18, 8'hC3);
        wr(0, 8'h20);
        cap.delete();
        wr(4, 8'h13);
        wait_idle();
        chk("R2", cap.size(), 5);
        chk("R2", int'(cap[0]), 8'h40);
        chk("R2", int'(cap[1]), 8'h36);
        chk("R2", int'(cap[4]), 8'hC3);
        rd(5, v); chk("R6", v, 8'h20);
        rd(0, v); chk("R6", v, 8'h00);
        chk("R8", int'(irq), 1);

        // R8 write-1-to-clear
        wr(5, 8'h20);
        rd(5, v); chk("R8", v, 0);
        chk("R8", int'(irq), 0);

        // R5 one negative result then acknowledge
        wr(0, 8'h20); nack_left = 1; cap.delete();
        wr(4, 8'h13);
        wait_idle();
        chk("R5", cap.size(), 10);
        chk("R5", int'(cap[5]), 8'h40);
        rd(0, v); chk("R6", v, 8'h10);
        wr(5, 8'h20);

        // R7 exhaustion with a two-attempt budget
        wr(0, 8'h10); nack_all = 1; cap.delete();
        wr(4, 8'h12);
        wait_idle();
        nack_all = 0;
        chk("R7", cap.size(), 8);
        rd(6, v); chk("R7", v, 8'h02);
        rd(5, v); chk("R7", v, 0);
        rd(0, v); chk("R7", v, 8'h10);
        chk("R8", int'(irq), 1);
        wr(6, 2);
        chk("R8", int'(irq), 0);

        // R4 poll
        wr(0, 0); cap.delete();
        wr(2, 8'h8F);
        wait_idle();
        chk("R4", cap.size(), 1);
        chk("R4", int'(cap[0]), 8'h4F);
        rd(2, v); chk("R4", v, 8'h0F);
        wr(5, 8'h20);

        // R9 launch while busy is ignored
        rmode = 1; cap.delete();
        wr(4, 8'h11);
        repeat (3) @(negedge clk);
        rd(0, v); chk("R9", v & 1, 1);
        wr(4, 8'h13);
        wr(2, 8'h85);
        rmode = 0;
        wait_idle();
        chk("R9", cap.size(), 3);
        chk("R9", int'(cap[0]), 8'h4F);
        rd(0, v); chk("R9", v & 1, 0);
        wr(5, 8'h20);

        // R3 count clamp
        cap.delete();
        wr(4, 8'h1F);
        wait_idle();
        chk("R3", cap.size(), 16);
        rd(4, v); chk("R3", v, 14);
        wr(5, 8'h20);

        // R10 flush cuts into a stalled message
        rmode = 1;
        wr(4, 8'h13);
        repeat (2) @(negedge clk);
        wr(0, 8'h80);
        rd(0, v); chk("R10", (v >> 7) & 1, 1);
        wr(4, 8'h10);
        rmode = 0;
        wait_idle();
        rd(0, v); chk("R10", v, 0);
        rd(16, v); chk("R10", v, 0);
        rd(18, v); chk("R10", v, 0);
        rd(5, v); chk("R10", v, 0);
        chk("R10", int'(tx_valid), 0);

        // R5 mixed traffic with a random ready pattern
        rmode = 2;
        for (int k = 0; k < 6; k++) begin
            wr(16 + k, 8'h11 * (k + 1));
            wr(0, (k % 3) << 4);
            nack_left = k % 3;
            wr(4, 8'h10 | ((k * 3) % 15));
            wait_idle();
            rd(5, v); chk("R5", v, 8'h20);
            wr(5, 8'h20); wr(6, 2);
        end
        rmode = 0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule